// File: doc/BRIEF.md
# Dual-Convention Stack Pointer Unit

This block holds the 16-bit stack pointer of an 8-bit processor together with the address arithmetic around it. Each cycle it can accept one of five requests: push a byte, pull a byte, copy the pointer out to the index register, copy the index register into the pointer, or load the raw pointer value. For push and pull it produces the memory address of the byte access in the same cycle and updates the pointer at the next clock edge. The memory, the rest of the register file and instruction decode sit outside the block.

Two stack conventions are supported. In the empty-slot convention the pointer names the next free byte below the top of stack. A push writes at the pointer and then decrements it. A pull increments the pointer and then reads at the new value. Transfers to and from the index register add or subtract one, so that the index names the last pushed byte. In the full-stack convention the pointer names the last pushed byte. A push decrements first and then writes. A pull reads at the pointer and then increments it. Transfers copy the value unchanged. The raw load path and the raw pointer output are never adjusted, in either convention.

The convention is chosen by a mode input. The mode input is taken into the block only on idle cycles, so a change never lands in the middle of a run of stack operations. A push and a pull asked for in the same cycle are refused, and the refusal is reported with a one-cycle error strobe.

Top module: `spu_stack_ptr`

## Requirements
- R1: While reset is asserted and after it is released, `sp_o` equals parameter `RESET_SP` (default 16'h01FF), `err_o` is 0, `addr_valid_o` is 0, and the active convention is empty-slot.
- R2: In empty-slot convention (active mode 0), an accepted push drives `addr_o` = `sp_o` with `addr_valid_o` = 1 in the request cycle, and `sp_o` is one lower after the next rising edge.
- R3: In empty-slot convention, an accepted pull drives `addr_o` = `sp_o` + 1 with `addr_valid_o` = 1 in the request cycle, and `sp_o` is one higher after the next rising edge.
- R4: In full-stack convention (active mode 1), an accepted push drives `addr_o` = `sp_o` - 1 in the request cycle, and `sp_o` is one lower after the next rising edge.
- R5: In full-stack convention, an accepted pull drives `addr_o` = `sp_o` in the request cycle, and `sp_o` is one higher after the next rising edge.
- R6: `x_o`, the stack-to-index transfer value, equals `sp_o` + 1 in empty-slot convention and `sp_o` in full-stack convention, in the same cycle.
- R7: An index-to-stack transfer sets `sp_o` to `x_i` - 1 in empty-slot convention and to `x_i` in full-stack convention, after the next rising edge.
- R8: A raw load sets `sp_o` to `load_val_i` unchanged in both conventions. `sp_o` is the unadjusted pointer for raw stores.
- R9: All pointer and address arithmetic wraps modulo 2^16. A push at 16'h0000 gives 16'hFFFF, and an empty-slot pull at 16'hFFFF addresses 16'h0000.
- R10: When `push_i` and `pull_i` are both high, nothing is accepted that cycle. `addr_valid_o` is 0, `sp_o` is unchanged even if other requests are present, and `err_o` is 1 for exactly the following cycle.
- R11: `mode_i` (0 = empty-slot, 1 = full-stack) is latched only at the edge that ends a cycle with no request. A change of `mode_i` during a run of requests has no effect until an idle cycle has passed.
- R12: Requests are served in priority order: raw load, then index-to-stack, then push or pull. A lower-priority push or pull that is not served drives `addr_valid_o` = 0 and does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | Requested convention: 0 empty-slot, 1 full-stack |
| push_i | input | 1 | Push one byte |
| pull_i | input | 1 | Pull one byte |
| s2x_i | input | 1 | Stack-to-index transfer in progress (counts as busy) |
| x2s_i | input | 1 | Index-to-stack transfer |
| x_i | input | 16 | Index register value for index-to-stack |
| load_i | input | 1 | Raw pointer load |
| load_val_i | input | 16 | Raw value for load |
| sp_o | output | 16 | Raw pointer value (store path) |
| addr_o | output | 16 | Byte address of the accepted push or pull |
| addr_valid_o | output | 1 | A push or pull is accepted this cycle |
| x_o | output | 16 | Value for stack-to-index transfer |
| err_o | output | 1 | Strobe: simultaneous push and pull refused last cycle |

## Verification
`addr_o`, `addr_valid_o` and `x_o` are combinational and are due in the request cycle itself. The bench drives each request just after a falling edge and samples them 1 ns later, before any rising edge. `sp_o` and `err_o` move at the rising edge that ends the request cycle, so the bench reads them at the following falling edge. A mode change needs one idle cycle to latch, and the next request after it is the first to use the new convention. The bench's reference pointer is updated only at the points where these results are due.

// File: rtl/spu_pkg.sv
package spu_pkg;

  localparam int SPW = 16;

  typedef logic [SPW-1:0] sp_t;

  typedef enum logic {
    CONV_EMPTY = 1'b0,
    CONV_FULL  = 1'b1
  } conv_e;

  // pointer movement is the same in both conventions
  function automatic sp_t ptr_after_push(input sp_t sp);
    return sp - sp_t'(1);
  endfunction

  function automatic sp_t ptr_after_pull(input sp_t sp);
    return sp + sp_t'(1);
  endfunction

  // byte address touched by a push
  function automatic sp_t push_addr(input conv_e conv, input sp_t sp);
    return (conv == CONV_FULL) ? sp - sp_t'(1) : sp;
  endfunction

  // byte address touched by a pull
  function automatic sp_t pull_addr(input conv_e conv, input sp_t sp);
    return (conv == CONV_FULL) ? sp : sp + sp_t'(1);
  endfunction

  // value handed to the index register
  function automatic sp_t to_index(input conv_e conv, input sp_t sp);
    return (conv == CONV_FULL) ? sp : sp + sp_t'(1);
  endfunction

  // value taken from the index register
  function automatic sp_t from_index(input conv_e conv, input sp_t x);
    return (conv == CONV_FULL) ? x : x - sp_t'(1);
  endfunction

endpackage

// File: rtl/spu_mode_latch.sv
module spu_mode_latch
  import spu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  busy,
  input  logic  mode_req,
  output conv_e conv
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv <= CONV_EMPTY;
    end else if (!busy) begin
      conv <= conv_e'(mode_req);
    end
  end

endmodule

// File: rtl/spu_addr_gen.sv
module spu_addr_gen
  import spu_pkg::*;
(
  input  conv_e conv,
  input  sp_t   sp,
  input  logic  push_acc,
  input  logic  pull_acc,
  output sp_t   addr,
  output logic  addr_valid,
  output sp_t   x_val
);

  always_comb begin
    addr = '0;
    if (push_acc) begin
      addr = push_addr(conv, sp);
    end else if (pull_acc) begin
      addr = pull_addr(conv, sp);
    end
  end

  assign addr_valid = push_acc | pull_acc;
  assign x_val      = to_index(conv, sp);

endmodule

// File: rtl/spu_ptr_reg.sv
module spu_ptr_reg
  import spu_pkg::*;
#(
  parameter sp_t RESET_SP = sp_t'(16'h01FF)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  conv_e conv,
  input  logic  reject,
  input  logic  load_sel,
  input  logic  x2s_sel,
  input  logic  push_acc,
  input  logic  pull_acc,
  input  sp_t   load_val,
  input  sp_t   x_val,
  output sp_t   sp,
  output logic  err
);

  sp_t sp_nxt;

  always_comb begin
    sp_nxt = sp;
    if (load_sel) begin
      sp_nxt = load_val;
    end else if (x2s_sel) begin
      sp_nxt = from_index(conv, x_val);
    end else if (push_acc) begin
      sp_nxt = ptr_after_push(sp);
    end else if (pull_acc) begin
      sp_nxt = ptr_after_pull(sp);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp  <= RESET_SP;
      err <= 1'b0;
    end else begin
      sp  <= sp_nxt;
      err <= reject;
    end
  end

endmodule

// File: rtl/spu_stack_ptr.sv
module spu_stack_ptr
  import spu_pkg::*;
#(
  parameter sp_t RESET_SP = sp_t'(16'h01FF)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_i,
  input  logic           push_i,
  input  logic           pull_i,
  input  logic           s2x_i,
  input  logic           x2s_i,
  input  logic [SPW-1:0] x_i,
  input  logic           load_i,
  input  logic [SPW-1:0] load_val_i,
  output logic [SPW-1:0] sp_o,
  output logic [SPW-1:0] addr_o,
  output logic           addr_valid_o,
  output logic [SPW-1:0] x_o,
  output logic           err_o
);

  // named internal events, visible to the bound checker
  logic  busy;
  logic  reject;
  logic  load_sel;
  logic  x2s_sel;
  logic  push_acc;
  logic  pull_acc;
  conv_e conv;
  sp_t   sp;

  assign busy     = push_i | pull_i | s2x_i | x2s_i | load_i;
  assign reject   = push_i & pull_i;
  assign load_sel = load_i & ~reject;
  assign x2s_sel  = x2s_i & ~load_i & ~reject;
  assign push_acc = push_i & ~pull_i & ~load_i & ~x2s_i;
  assign pull_acc = pull_i & ~push_i & ~load_i & ~x2s_i;

  spu_mode_latch u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .mode_req (mode_i),
    .conv     (conv)
  );

  spu_ptr_reg #(
    .RESET_SP (RESET_SP)
  ) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .conv     (conv),
    .reject   (reject),
    .load_sel (load_sel),
    .x2s_sel  (x2s_sel),
    .push_acc (push_acc),
    .pull_acc (pull_acc),
    .load_val (load_val_i),
    .x_val    (x_i),
    .sp       (sp),
    .err      (err_o)
  );

  spu_addr_gen u_addr (
    .conv       (conv),
    .sp         (sp),
    .push_acc   (push_acc),
    .pull_acc   (pull_acc),
    .addr       (addr_o),
    .addr_valid (addr_valid_o),
    .x_val      (x_o)
  );

  assign sp_o = sp;

endmodule

// File: rtl/spu_stack_ptr_chk.sv
module spu_stack_ptr_chk
  import spu_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           push_i,
  input logic           pull_i,
  input logic           load_i,
  input logic [SPW-1:0] load_val_i,
  input logic [SPW-1:0] sp_o,
  input logic [SPW-1:0] addr_o,
  input logic           addr_valid_o,
  input logic           err_o,
  input logic           busy,
  input logic           push_acc,
  input logic           pull_acc,
  input logic           conv
);

  p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc |=> sp_o == $past(sp_o) - 16'd1);

  p_pull_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pull_acc |=> sp_o == $past(sp_o) + 16'd1);

  p_empty_push_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc && !conv) |-> addr_o == sp_o);

  p_full_pull_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_acc && conv) |-> addr_o == sp_o);

  p_load_raw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !(push_i && pull_i)) |=> sp_o == $past(load_val_i));

  p_reject_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pull_i) |=> (err_o && $stable(sp_o)));

  p_reject_no_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pull_i) |-> !addr_valid_o);

  p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(conv));

endmodule

bind spu_stack_ptr spu_stack_ptr_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .push_i       (push_i),
  .pull_i       (pull_i),
  .load_i       (load_i),
  .load_val_i   (load_val_i),
  .sp_o         (sp_o),
  .addr_o       (addr_o),
  .addr_valid_o (addr_valid_o),
  .err_o        (err_o),
  .busy         (busy),
  .push_acc     (push_acc),
  .pull_acc     (pull_acc),
  .conv         (conv)
);

// File: tb/spu_stack_ptr_bench.sv
`timescale 1ns/1ps
module spu_stack_ptr_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_i = 1'b0;
  logic        push_i = 1'b0;
  logic        pull_i = 1'b0;
  logic        s2x_i = 1'b0;
  logic        x2s_i = 1'b0;
  logic [15:0] x_i = '0;
  logic        load_i = 1'b0;
  logic [15:0] load_val_i = '0;
  logic [15:0] sp_o;
  logic [15:0] addr_o;
  logic        addr_valid_o;
  logic [15:0] x_o;
  logic        err_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] ref_sp;

  always #5 clk = ~clk;

  spu_stack_ptr u_spu_stack_ptr (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .push_i(push_i), .pull_i(pull_i),
    .s2x_i(s2x_i), .x2s_i(x2s_i), .x_i(x_i), .load_i(load_i),
    .load_val_i(load_val_i), .sp_o(sp_o), .addr_o(addr_o),
    .addr_valid_o(addr_valid_o), .x_o(x_o), .err_o(err_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive a request set at a falling edge and let combinational outputs settle
  task automatic drive(input logic pu, input logic pl, input logic s2x,
                       input logic x2s, input logic [15:0] xv,
                       input logic ld, input logic [15:0] lv);
    push_i = pu; pull_i = pl; s2x_i = s2x; x2s_i = x2s; x_i = xv;
    load_i = ld; load_val_i = lv;
    #1;
  endtask

  // finish the cycle: registered results are read at the next falling edge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, '0, 0, '0);
    step();
  endtask

  task automatic set_mode(input logic m);
    mode_i = m;
    idle();
  endtask

  task automatic load_ptr(input logic [15:0] v);
    drive(0, 0, 0, 0, '0, 1, v);
    step();
    ref_sp = v;
    chk("R8 raw load", sp_o, ref_sp);
    idle();
  endtask

  task automatic t_reset();
    chk("R1 reset sp", sp_o, 16'h01FF);
    chk("R1 reset err", 16'(err_o), 16'h0);
    chk("R1 reset addr_valid", 16'(addr_valid_o), 16'h0);
    chk("R1 reset x_o empty-slot", x_o, 16'h0200);
    ref_sp = 16'h01FF;
  endtask

  task automatic t_empty_push_pull();
    load_ptr(16'h0400);
    drive(1, 0, 0, 0, '0, 0, '0);
    chk("R2 push addr", addr_o, ref_sp);
    chk("R2 push valid", 16'(addr_valid_o), 16'h1);
    step();
    ref_sp = ref_sp - 16'd1;
    chk("R2 push sp", sp_o, ref_sp);
    drive(0, 1, 0, 0, '0, 0, '0);
    chk("R3 pull addr", addr_o, ref_sp + 16'd1);
    chk("R3 pull valid", 16'(addr_valid_o), 16'h1);
    step();
    ref_sp = ref_sp + 16'd1;
    chk("R3 pull sp", sp_o, ref_sp);
    idle();
  endtask

  task automatic t_empty_transfers();
    chk("R6 s2x empty-slot", x_o, ref_sp + 16'd1);
    drive(0, 0, 0, 1, 16'h1234, 0, '0);
    step();
    ref_sp = 16'h1233;
    chk("R7 x2s empty-slot", sp_o, ref_sp);
    idle();
  endtask

  task automatic t_full_mode();
    set_mode(1'b1);
    load_ptr(16'h0800);
    chk("R8 raw sp not adjusted in full", sp_o, 16'h0800);
    chk("R6 s2x full", x_o, ref_sp);
    drive(1, 0, 0, 0, '0, 0, '0);
    chk("R4 push addr", addr_o, ref_sp - 16'd1);
    step();
    ref_sp = ref_sp - 16'd1;
    chk("R4 push sp", sp_o, ref_sp);
    drive(0, 1, 0, 0, '0, 0, '0);
    chk("R5 pull addr", addr_o, ref_sp);
    step();
    ref_sp = ref_sp + 16'd1;
    chk("R5 pull sp", sp_o, ref_sp);
    drive(0, 0, 0, 1, 16'h4321, 0, '0);
    step();
    ref_sp = 16'h4321;
    chk("R7 x2s full", sp_o, ref_sp);
    idle();
    set_mode(1'b0);
  endtask

  task automatic t_wrap();
    load_ptr(16'h0000);
    drive(1, 0, 0, 0, '0, 0, '0);
    chk("R9 push addr at zero", addr_o, 16'h0000);
    step();
    chk("R9 push wraps", sp_o, 16'hFFFF);
    drive(0, 1, 0, 0, '0, 0, '0);
    chk("R9 pull addr wraps", addr_o, 16'h0000);
    step();
    chk("R9 pull wraps", sp_o, 16'h0000);
    idle();
    ref_sp = 16'h0000;
  endtask

  task automatic t_reject();
    load_ptr(16'h0300);
    drive(1, 1, 0, 0, '0, 1, 16'hBEEF);
    chk("R10 no access", 16'(addr_valid_o), 16'h0);
    step();
    chk("R10 sp held", sp_o, ref_sp);
    chk("R10 err strobe", 16'(err_o), 16'h1);
    idle();
    chk("R10 err one cycle", 16'(err_o), 16'h0);
  endtask

  task automatic t_mode_defer();
    load_ptr(16'h0500);
    mode_i = 1'b1;
    drive(1, 0, 0, 0, '0, 0, '0);
    chk("R11 mode not taken while busy (push)", addr_o, ref_sp);
    step();
    ref_sp = ref_sp - 16'd1;
    drive(0, 1, 0, 0, '0, 0, '0);
    chk("R11 mode still empty-slot (pull)", addr_o, ref_sp + 16'd1);
    step();
    ref_sp = ref_sp + 16'd1;
    idle();
    drive(1, 0, 0, 0, '0, 0, '0);
    chk("R11 full after idle", addr_o, ref_sp - 16'd1);
    step();
    ref_sp = ref_sp - 16'd1;
    idle();
    set_mode(1'b0);
  endtask

  task automatic t_priority();
    load_ptr(16'h0600);
    drive(1, 0, 0, 0, '0, 1, 16'h0A00);
    chk("R12 push lost to load", 16'(addr_valid_o), 16'h0);
    step();
    chk("R12 load wins", sp_o, 16'h0A00);
    drive(0, 1, 0, 1, 16'h0C00, 0, '0);
    chk("R12 pull lost to x2s", 16'(addr_valid_o), 16'h0);
    step();
    chk("R12 x2s wins", sp_o, 16'h0BFF);
    drive(0, 0, 0, 1, 16'h0D00, 1, 16'h0E00);
    step();
    chk("R12 load over x2s", sp_o, 16'h0E00);
    idle();
    ref_sp = 16'h0E00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", sp_o, 16'h01FF);
    t_empty_push_pull();
    t_empty_transfers();
    t_full_mode();
    t_wrap();
    t_reject();
    t_mode_defer();
    t_priority();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule